// File: doc/BRIEF.md
# Shared Timer Prescaler and Clock Select

This block produces one count-enable strobe per timer channel from a single system clock. A free-running binary counter is shared by all channels, and each channel picks its own source of counting with a 3-bit select field. The source can be no counting at all, every system cycle, a divided tap of the shared counter, or an edge of an external pin. The pin edge is synchronized to the clock and edge-detected before it is used. The timers that consume the strobes sit outside this block.

The shared counter runs whatever the channels select. A channel that switches to a divided tap therefore joins a period that is already in progress. A prescaler-reset input restarts that period for every channel at once.

The last channel has no external pin. In place of the two edge selections it offers two additional taps, /16 and /32.

Top module: `presc_clksel`

## Requirements
- R1: Select value 0 holds the channel's `en_o` bit low on every cycle.
- R2: Select value 1 drives `en_o` high on every cycle, including cycles in which `presc_rst_i` is high.
- R3: On a pin-equipped channel, select values 2, 3, 4 and 5 choose divisors 8, 64, 256 and 1024. The strobe is high for exactly one cycle, namely the cycle in which the low log2(N) bits of the shared counter are all ones. The counter starts at 0 after reset and advances by one per cycle.
- R4: On the last channel, select values 2, 3, 4 and 5 choose divisors 8, 64, 256 and 1024, and select values 6 and 7 choose divisors 16 and 32. The strobe rule is the same as in R3.
- R5: While `presc_rst_i` is high, no channel emits a tap strobe. The counter holds 0 in the cycle after a reset cycle, so a /N strobe next appears in the N-th cycle after `presc_rst_i` falls.
- R6: The shared counter ignores the select fields. After a channel switches to a /N tap, its first strobe arrives within the first N cycles that carry the new select.
- R7: On a pin-equipped channel, select value 6 emits exactly one one-cycle strobe per falling edge of the channel's pin, and select value 7 does the same per rising edge. Pin edges of the other polarity produce no strobe.
- R8: A pin change made while the clock is high after rising edge k shows its strobe in the cycle that begins at rising edge k+2. The strobe does not appear in the cycle that begins at edge k+1. The pin history updates even while the channel selects another source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| presc_rst_i | input | 1 | Restart of the shared prescaler period |
| sel_i | input | 3*NUM_CH | Per-channel select, channel c in bits [3c+2:3c] |
| ext_pin_i | input | NUM_CH-1 | External count pins of channels 0 to NUM_CH-2 |
| en_o | output | NUM_CH | Per-channel count-enable strobe |

## Verification
The hardest behaviour to reach from the ports is the combination of a select change partway through a long prescaler period with a prescaler reset that lands on or near a tap boundary. This matters most for /1024, which random stimulus with frequent resets would almost never complete. The stimulus therefore holds prescaler reset rare and changes selects at low probability, so that full /256 and /1024 periods do occur. It also adds directed runs: a reset followed by an exact strobe position, a mid-period switch to /64, and a single pin edge traced cycle by cycle through the synchronizer.

// File: rtl/presc_pkg.sv
package presc_pkg;
    localparam int SEL_W   = 3;
    localparam int NUM_TAP = 6;
    localparam int CNT_W   = 10;

    // tap index order: /8, /16, /32, /64, /256, /1024
    function automatic int tap_log2(input int idx);
        case (idx)
            0:       return 3;
            1:       return 4;
            2:       return 5;
            3:       return 6;
            4:       return 8;
            default: return 10;
        endcase
    endfunction

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    typedef struct packed {
        logic sync;
        logic hist;
        logic rise;
        logic fall;
    } edge_state_t;
endpackage

// File: rtl/presc_counter.sv
module presc_counter
    import presc_pkg::*;
(
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               presc_rst_i,
    output logic [NUM_TAP-1:0] tap_o,
    output logic [CNT_W-1:0]   cnt_o
);
    cnt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (presc_rst_i) st_d.cnt = '0;
        else             st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    for (genvar t = 0; t < NUM_TAP; t++) begin : g_tap
        localparam int L = tap_log2(t);
        assign tap_o[t] = (&st_q.cnt[L-1:0]) && !presc_rst_i;
    end

    assign cnt_o = st_q.cnt;

    p_prst_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        presc_rst_i |=> (st_q.cnt == '0));
    p_tap8_pulse_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tap_o[0] |=> !tap_o[0]);
endmodule

// File: rtl/pin_edge_sync.sv
module pin_edge_sync
    import presc_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic pin_i,
    output logic rise_o,
    output logic fall_o
);
    logic        lat_q;
    edge_state_t st_d, st_q;

    always_latch begin
        if (clk_i) lat_q <= pin_i;
    end

    always_comb begin
        st_d      = st_q;
        st_d.sync = lat_q;
        st_d.hist = st_q.sync;
        st_d.rise = st_q.sync && !st_q.hist;
        st_d.fall = !st_q.sync && st_q.hist;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign rise_o = st_q.rise;
    assign fall_o = st_q.fall;

    p_edge_excl_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(st_q.rise && st_q.fall));
    p_rise_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.rise |=> !st_q.rise);
    p_fall_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.fall |=> !st_q.fall);
endmodule

// File: rtl/presc_clksel.sv
module presc_clksel
    import presc_pkg::*;
#(
    parameter int NUM_CH = 3
) (
    input  logic                    clk_i,
    input  logic                    rst_ni,
    input  logic                    presc_rst_i,
    input  logic [SEL_W*NUM_CH-1:0] sel_i,
    input  logic [NUM_CH-2:0]       ext_pin_i,
    output logic [NUM_CH-1:0]       en_o
);
    localparam int LAST = NUM_CH - 1;

    logic [NUM_TAP-1:0] tap;
    logic [CNT_W-1:0]   cnt;

    presc_counter u_cnt (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .presc_rst_i (presc_rst_i),
        .tap_o       (tap),
        .cnt_o       (cnt)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic [SEL_W-1:0] sel;
        assign sel = sel_i[SEL_W*c +: SEL_W];

        if (c < LAST) begin : g_std
            logic rise, fall;
            pin_edge_sync u_sync (
                .clk_i  (clk_i),
                .rst_ni (rst_ni),
                .pin_i  (ext_pin_i[c]),
                .rise_o (rise),
                .fall_o (fall)
            );
            always_comb begin
                case (sel)
                    3'd0:    en_o[c] = 1'b0;
                    3'd1:    en_o[c] = 1'b1;
                    3'd2:    en_o[c] = tap[0];
                    3'd3:    en_o[c] = tap[3];
                    3'd4:    en_o[c] = tap[4];
                    3'd5:    en_o[c] = tap[5];
                    3'd6:    en_o[c] = fall;
                    default: en_o[c] = rise;
                endcase
            end
        end else begin : g_wide
            always_comb begin
                case (sel)
                    3'd0:    en_o[c] = 1'b0;
                    3'd1:    en_o[c] = 1'b1;
                    3'd2:    en_o[c] = tap[0];
                    3'd3:    en_o[c] = tap[3];
                    3'd4:    en_o[c] = tap[4];
                    3'd5:    en_o[c] = tap[5];
                    3'd6:    en_o[c] = tap[1];
                    default: en_o[c] = tap[2];
                endcase
            end
        end

        p_tap_en_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (en_o[c] && sel == 3'd2) |-> (&cnt[2:0]));
        p_prst_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (presc_rst_i && sel >= 3'd2 && sel <= 3'd5) |-> !en_o[c]);
    end
endmodule

// File: tb/presc_clksel_test.sv
module presc_clksel_test;
    localparam int  PERIOD = 10;
    localparam int  NCH    = 3;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           prst = 1'b0;
    logic [3*NCH-1:0] sel = '0;
    logic [NCH-2:0] pin = '0;
    logic [NCH-1:0] en;

    int n_chk = 0;
    int n_fail = 0;

    // bench model state
    int m_cnt = 0;
    bit m_sync [NCH-1];
    bit m_hist [NCH-1];
    bit m_rise [NCH-1];
    bit m_fall [NCH-1];

    presc_clksel #(.NUM_CH(NCH)) uut (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .presc_rst_i (prst),
        .sel_i       (sel),
        .ext_pin_i   (pin),
        .en_o        (en)
    );

    always #(PERIOD/2) clk = ~clk;

    initial begin
        #(PERIOD*200000);
        n_fail++;
        $display("FAIL watchdog: run did not end, actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    function automatic bit tap_hit(int lg, int cnt, bit pr);
        int m = (1 << lg) - 1;
        return ((cnt & m) == m) && !pr;
    endfunction

    function automatic bit exp_en(int c, int s, int cnt, bit pr, bit r, bit f);
        case (s)
            0: return 1'b0;
            1: return 1'b1;
            2: return tap_hit(3, cnt, pr);
            3: return tap_hit(6, cnt, pr);
            4: return tap_hit(8, cnt, pr);
            5: return tap_hit(10, cnt, pr);
            6: return (c == NCH-1) ? tap_hit(4, cnt, pr) : f;
            default: return (c == NCH-1) ? tap_hit(5, cnt, pr) : r;
        endcase
    endfunction

    function automatic string req_of(int c, int s);
        if (s == 0) return "R1";
        if (s == 1) return "R2";
        if (c == NCH-1) return "R4";
        if (s >= 6) return "R7";
        return "R3";
    endfunction

    task automatic check(string req, bit act, bit exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0b expected=%0b at %0t", req, act, exp, $time);
        end
    endtask

    // advance one clock: update model with held inputs, then apply new inputs
    task automatic step(logic pr_n, logic [3*NCH-1:0] s_n, logic [NCH-2:0] p_n);
        @(posedge clk);
        if (!rst_n) m_cnt = 0;
        else if (prst) m_cnt = 0;
        else m_cnt = (m_cnt + 1) % 1024;
        for (int c = 0; c < NCH-1; c++) begin
            if (!rst_n) begin
                m_rise[c] = 0; m_fall[c] = 0; m_hist[c] = 0; m_sync[c] = 0;
            end else begin
                m_rise[c] = m_sync[c] && !m_hist[c];
                m_fall[c] = !m_sync[c] && m_hist[c];
                m_hist[c] = m_sync[c];
                m_sync[c] = pin[c];
            end
        end
        #1;
        prst = pr_n; sel = s_n; pin = p_n;
        #2;
    endtask

    task automatic compare_all();
        for (int c = 0; c < NCH; c++) begin
            int s = int'(sel[3*c +: 3]);
            bit r = (c < NCH-1) ? m_rise[c] : 1'b0;
            bit f = (c < NCH-1) ? m_fall[c] : 1'b0;
            check(req_of(c, s), en[c], exp_en(c, s, m_cnt, prst, r, f));
        end
    endtask

    initial begin
        logic [3*NCH-1:0] s_v;
        logic [NCH-2:0]   p_v;
        int               wait_n;
        void'($urandom(32'h5eed_1234));

        step(0, '0, '0);
        step(0, '0, '0);
        rst_n = 1'b1;
        // reset state: select 0 everywhere, no strobes
        step(0, '0, '0);
        check("R1", en[0], 1'b0);
        check("R1", |en, 1'b0);

        // R2: select 1 keeps strobing during prescaler reset
        step(1, {3'd1, 3'd1, 3'd1}, '0);
        check("R2", &en, 1'b1);
        compare_all();

        // R5: after reset falls, /8 strobe appears in 8th cycle
        step(0, {3'd2, 3'd2, 3'd2}, '0);
        for (int k = 1; k <= 8; k++) begin
            check("R5", en[0], (k == 8));
            compare_all();
            step(0, {3'd2, 3'd2, 3'd2}, '0);
        end

        // R4: wide channel /16 and /32
        step(1, {3'd6, 3'd0, 3'd0}, '0);
        for (int k = 1; k <= 40; k++) begin
            step(0, (k < 20) ? {3'd6, 3'd0, 3'd0} : {3'd7, 3'd0, 3'd0}, '0);
            compare_all();
        end

        // R6: switch to /64 mid-period, first strobe within 64 cycles
        step(0, '0, '0);
        repeat (37) step(0, '0, '0);
        step(0, {3'd0, 3'd3, 3'd0}, '0);
        wait_n = 1;
        while (!en[1] && wait_n <= 70) begin
            step(0, {3'd0, 3'd3, 3'd0}, '0);
            wait_n++;
        end
        check("R6", (wait_n >= 1 && wait_n <= 64), 1'b1);

        // R8/R7: single rising edge on pin 0 with select 7, history under select 0 on pin 1
        step(0, {3'd0, 3'd0, 3'd7}, 2'b00);
        step(0, {3'd0, 3'd0, 3'd7}, 2'b00);
        step(0, {3'd0, 3'd0, 3'd7}, 2'b11);   // edge k
        check("R8", en[0], 1'b0);
        step(0, {3'd0, 3'd0, 3'd7}, 2'b11);   // edge k+1
        check("R8", en[0], 1'b0);
        step(0, {3'd0, 3'd7, 3'd7}, 2'b11);   // edge k+2
        check("R8", en[0], 1'b1);
        check("R8", en[1], 1'b1);
        step(0, {3'd0, 3'd7, 3'd7}, 2'b11);
        check("R7", en[0], 1'b0);
        // falling edge under rising select: no strobe
        step(0, {3'd0, 3'd7, 3'd7}, 2'b00);
        step(0, {3'd0, 3'd7, 3'd7}, 2'b00);
        step(0, {3'd0, 3'd7, 3'd7}, 2'b00);
        check("R7", en[0], 1'b0);
        compare_all();

        // constrained random mix
        s_v = sel; p_v = pin;
        for (int i = 0; i < 30000; i++) begin
            if ($urandom_range(0, 199) == 0) begin
                for (int c = 0; c < NCH; c++) s_v[3*c +: 3] = 3'($urandom_range(0, 7));
            end
            if ($urandom_range(0, 5) == 0) p_v = (NCH-1)'($urandom);
            step(($urandom_range(0, 2999) == 0), s_v, p_v);
            compare_all();
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule